// File: doc/BRIEF.md
# Time-Multiplexed Neural Population Unit

This block stands in for a large set of neural populations with one shared arithmetic datapath. It does not simulate spiking neurons. Each population holds one represented value and its own decoder weights. All populations on the unit share a small bank of basis-function tables, which approximate the principal components of the tuning curves. A population's output is the weighted sum of the basis tables read at that population's value, plus a scaled pseudo-random term that models spike-related fluctuation.

Before a run, a host loads the input values, weights, basis tables and per-population noise amplitudes through one write port. The logic itself never changes for a new network. Each timestep strobe starts a sweep that visits every population in index order, three clock cycles per population. Each result is streamed out with its index. A done flag marks the end of the sweep. With 1024 populations a sweep takes 3072 cycles, well inside a 1 ms step at any usual clock rate.

Top module: `popmux_unit`

## Requirements
- R1: While reset is held and right after it, out_valid_o, done_o and overrun_o are 0, and no output appears until a strobe is given.
- R2: A strobe accepted while idle starts a sweep. The sweep gives exactly NPOP outputs with out_idx_o = 0, 1, …, NPOP-1, one every 3 cycles. The first output is valid 3 cycles after the strobe edge, and done_o rises together with the last output, 3·NPOP cycles after the strobe edge.
- R3: The output value is sat12(floor(Σk w[p][k]·b[k]/2^11) + noise). w and b are signed 12-bit values, so the Q1.11 products are rescaled back to Q1.11.
- R4: b[k] is the entry of basis table k at index {~x[11], x[10:4]}, where x is the population's signed 12-bit input. The most negative input reads entry 0 and zero reads entry 128.
- R5: Results beyond the signed 12-bit range clamp to 2047 or -2048 instead of wrapping.
- R6: noise = floor(s[15:4]·a/256). Here s[15:4] is taken as signed, s is the noise generator state before its step, and a is the unsigned 8-bit amplitude of the population. An amplitude of 0 removes the noise.
- R7: The noise generator is a 16-bit shift register with seed 0xACE1 after reset. Its next state is {s[14:0], s15^s13^s12^s10}. It steps once per population evaluated and keeps its state from one sweep to the next.
- R8: A strobe that arrives during a sweep sets overrun_o, which stays 1 until reset. That strobe is otherwise ignored: the sweep neither restarts nor lengthens.
- R9: done_o stays 1 after a sweep until the next accepted strobe, and is 0 in the cycle after that strobe's edge.
- R10: Write port selector codes are 0 = input value (address p), 1 = weight (address p·NBASIS+k), 2 = basis entry (address e·NBASIS+k) and 3 = noise amplitude (address p, data bits 7:0). Written contents persist across sweeps and decide every later result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| step_i | input | 1 | Timestep strobe |
| wr_en_i | input | 1 | Load write enable |
| wr_sel_i | input | 2 | Target memory selector |
| wr_addr_i | input | log2(NBASIS)+max(log2(NPOP),LUT_BITS) | Load address |
| wr_data_i | input | DW | Load data |
| out_valid_o | output | 1 | Result valid pulse |
| out_idx_o | output | log2(NPOP) | Index of the population for the result |
| out_val_o | output | DW | Signed saturated result |
| done_o | output | 1 | Sweep finished |
| overrun_o | output | 1 | Sticky flag for a strobe that came during a sweep |

## Verification
The bench builds the unit with NPOP = 8 and keeps NBASIS = 8, LUT_BITS = 8 and DW = 12. With only eight populations a sweep lasts 24 cycles. This lets many sweeps run, including a strobe injected mid-sweep and the carry of noise state between sweeps. At the same time every lane of the full-size 256-entry basis tables is written. Random networks are mixed with directed saturating networks and with networks whose noise amplitude is zero.

// File: rtl/popmux_pkg.sv
package popmux_pkg;
  typedef enum logic [1:0] {
    WS_INPUT  = 2'd0,
    WS_WEIGHT = 2'd1,
    WS_BASIS  = 2'd2,
    WS_AMP    = 2'd3
  } wsel_e;

  typedef enum logic {S_IDLE = 1'b0, S_RUN = 1'b1} state_e;

  localparam logic [15:0] NOISE_SEED = 16'hACE1;
  localparam logic [15:0] NOISE_TAPS = 16'hB400;
endpackage

// File: rtl/popmux_lfsr.sv
module popmux_lfsr #(
  parameter int          W    = 16,
  parameter logic [W-1:0] SEED = '1,
  parameter logic [W-1:0] TAPS = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         adv,
  output logic [W-1:0] state_o
);
  logic [W-1:0] st_q;
  logic         fb;

  assign fb      = ^(st_q & TAPS);
  assign state_o = st_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   st_q <= SEED;
    else if (adv) st_q <= {st_q[W-2:0], fb};
  end

  // R7: a maximal-length register never reaches zero
  p_lfsr_nonzero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    st_q != '0);
  // R7: each evaluation moves the state
  p_lfsr_steps_r7: assert property (@(posedge clk) disable iff (!rst_n)
    adv |=> st_q != $past(st_q));
endmodule

// File: rtl/popmux_ram.sv
module popmux_ram #(
  parameter int DEPTH = 16,
  parameter int W     = 12,
  localparam int AB   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AB-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AB-1:0] raddr,
  output logic [W-1:0]  rdata
);
  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/popmux_lanemem.sv
module popmux_lanemem #(
  parameter int DEPTH = 16,
  parameter int LANES = 8,
  parameter int W     = 12,
  localparam int AB   = $clog2(DEPTH),
  localparam int LB   = $clog2(LANES)
) (
  input  logic            clk,
  input  logic            we,
  input  logic [AB-1:0]   waddr,
  input  logic [LB-1:0]   wlane,
  input  logic [W-1:0]    wdata,
  input  logic [AB-1:0]   raddr,
  output logic [LANES*W-1:0] rdata
);
  logic [LANES*W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    for (int l = 0; l < LANES; l++) begin
      if (we && wlane == LB'(l)) mem[waddr][l*W +: W] <= wdata;
    end
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/popmux_unit.sv
module popmux_unit
  import popmux_pkg::*;
#(
  parameter int NPOP     = 1024,
  parameter int NBASIS   = 8,
  parameter int LUT_BITS = 8,
  parameter int DW       = 12,
  parameter int AMPW     = 8,
  localparam int PB      = $clog2(NPOP),
  localparam int LB      = $clog2(NBASIS),
  localparam int AW      = LB + ((PB > LUT_BITS) ? PB : LUT_BITS),
  localparam int ACCW    = 2*DW + LB,
  localparam int TW      = ACCW + 1,
  localparam int NZW     = DW + AMPW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          step_i,
  input  logic          wr_en_i,
  input  logic [1:0]    wr_sel_i,
  input  logic [AW-1:0] wr_addr_i,
  input  logic [DW-1:0] wr_data_i,
  output logic          out_valid_o,
  output logic [PB-1:0] out_idx_o,
  output logic [DW-1:0] out_val_o,
  output logic          done_o,
  output logic          overrun_o
);
  // ---------------- arithmetic helpers ----------------
  function automatic logic [LUT_BITS-1:0] lut_index(input logic [DW-1:0] x);
    return {~x[DW-1], x[DW-2 -: LUT_BITS-1]};
  endfunction

  function automatic logic [DW-1:0] sat_dw(input logic signed [TW-1:0] v);
    logic signed [TW-1:0] hi, lo;
    hi = TW'(2**(DW-1) - 1);
    lo = -TW'(2**(DW-1));
    if (v > hi)      return hi[DW-1:0];
    else if (v < lo) return lo[DW-1:0];
    else             return v[DW-1:0];
  endfunction

  // ---------------- sequencer state ----------------
  state_e        state_q;
  logic [PB-1:0] idx_q;
  logic [1:0]    phase_q;
  logic          busy, pop_fire, last_pop, step_ok, step_over;

  assign busy      = (state_q == S_RUN);
  assign pop_fire  = busy && (phase_q == 2'd2);
  assign last_pop  = (idx_q == PB'(NPOP - 1));
  assign step_ok   = step_i && !busy;
  assign step_over = step_i && busy;

  // ---------------- memories ----------------
  logic               we_inp, we_wgt, we_bas, we_amp;
  logic [DW-1:0]      inp_q;
  logic [AMPW-1:0]    amp_q;
  logic [NBASIS*DW-1:0] wgt_q, bas_q;
  logic [15:0]        noise_s;

  assign we_inp = wr_en_i && (wr_sel_i == WS_INPUT);
  assign we_wgt = wr_en_i && (wr_sel_i == WS_WEIGHT);
  assign we_bas = wr_en_i && (wr_sel_i == WS_BASIS);
  assign we_amp = wr_en_i && (wr_sel_i == WS_AMP);

  popmux_ram #(.DEPTH(NPOP), .W(DW)) u_inp (
    .clk(clk), .we(we_inp), .waddr(wr_addr_i[PB-1:0]), .wdata(wr_data_i),
    .raddr(idx_q), .rdata(inp_q));

  popmux_ram #(.DEPTH(NPOP), .W(AMPW)) u_amp (
    .clk(clk), .we(we_amp), .waddr(wr_addr_i[PB-1:0]), .wdata(wr_data_i[AMPW-1:0]),
    .raddr(idx_q), .rdata(amp_q));

  popmux_lanemem #(.DEPTH(NPOP), .LANES(NBASIS), .W(DW)) u_wgt (
    .clk(clk), .we(we_wgt), .waddr(wr_addr_i[LB +: PB]), .wlane(wr_addr_i[LB-1:0]),
    .wdata(wr_data_i), .raddr(idx_q), .rdata(wgt_q));

  popmux_lanemem #(.DEPTH(2**LUT_BITS), .LANES(NBASIS), .W(DW)) u_bas (
    .clk(clk), .we(we_bas), .waddr(wr_addr_i[LB +: LUT_BITS]), .wlane(wr_addr_i[LB-1:0]),
    .wdata(wr_data_i), .raddr(lut_index(inp_q)), .rdata(bas_q));

  popmux_lfsr #(.W(16), .SEED(NOISE_SEED), .TAPS(NOISE_TAPS)) u_lfsr (
    .clk(clk), .rst_n(rst_n), .adv(pop_fire), .state_o(noise_s));

  // ---------------- datapath ----------------
  logic signed [2*DW-1:0] prod [NBASIS];
  logic signed [ACCW-1:0] acc;
  logic signed [NZW-1:0]  nz_full, nz;
  logic signed [TW-1:0]   total;
  logic [DW-1:0]          result;

  for (genvar k = 0; k < NBASIS; k++) begin : g_lane
    assign prod[k] = $signed(wgt_q[k*DW +: DW]) * $signed(bas_q[k*DW +: DW]);
  end

  always_comb begin
    acc = '0;
    for (int k = 0; k < NBASIS; k++) acc = acc + ACCW'(prod[k]);
    nz_full = $signed(noise_s[15 -: DW]) * $signed({1'b0, amp_q});
    nz      = nz_full >>> AMPW;
    total   = TW'(acc >>> (DW - 1)) + TW'(nz);
    result  = sat_dw(total);
  end

  // ---------------- control ----------------
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= S_IDLE;
      idx_q       <= '0;
      phase_q     <= '0;
      done_o      <= 1'b0;
      overrun_o   <= 1'b0;
      out_valid_o <= 1'b0;
      out_idx_o   <= '0;
      out_val_o   <= '0;
    end else begin
      out_valid_o <= pop_fire;
      if (pop_fire) begin
        out_idx_o <= idx_q;
        out_val_o <= result;
      end
      if (step_over) overrun_o <= 1'b1;
      if (step_ok) begin
        state_q <= S_RUN;
        idx_q   <= '0;
        phase_q <= '0;
        done_o  <= 1'b0;
      end else if (busy) begin
        if (pop_fire) begin
          phase_q <= '0;
          if (last_pop) begin
            state_q <= S_IDLE;
            done_o  <= 1'b1;
          end else begin
            idx_q <= idx_q + 1'b1;
          end
        end else begin
          phase_q <= phase_q + 1'b1;
        end
      end
    end
  end

  // ---------------- assertions ----------------
  p_fire_emits_r2: assert property (@(posedge clk) disable iff (!rst_n)
    pop_fire |=> out_valid_o && out_idx_o == $past(idx_q));
  p_done_on_last_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_o) |-> out_valid_o && out_idx_o == PB'(NPOP - 1));
  p_over_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
    step_over |=> overrun_o);
  p_over_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    overrun_o |=> overrun_o);
  p_over_no_restart_r8: assert property (@(posedge clk) disable iff (!rst_n)
    step_over && !pop_fire |=> busy && idx_q == $past(idx_q));
  p_done_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    step_ok |=> !done_o && busy);
  p_idle_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && !step_i |=> !out_valid_o);
endmodule

// File: tb/sim_popmux_unit.sv
module sim_popmux_unit;
  localparam int CLK_PERIOD = 10;
  localparam int NPOP = 8;
  localparam int NB   = 8;
  localparam int LB   = 3;
  localparam int NLUT = 256;
  localparam int AW   = 11;

  logic clk = 0, rst_n = 0, step = 0, wr_en = 0;
  logic [1:0] wr_sel = 0;
  logic [AW-1:0] wr_addr = 0;
  logic [11:0] wr_data = 0;
  logic out_valid, done, overrun;
  logic [2:0] out_idx;
  logic [11:0] out_val;

  int total = 0, bad = 0;
  bit finished = 0;

  int inp_m [NPOP];
  int w_m   [NPOP][NB];
  int b_m   [NLUT][NB];
  int a_m   [NPOP];
  logic [15:0] ns;

  always #(CLK_PERIOD/2) clk = ~clk;

  popmux_unit #(.NPOP(NPOP)) u0 (
    .clk(clk), .rst_n(rst_n), .step_i(step), .wr_en_i(wr_en), .wr_sel_i(wr_sel),
    .wr_addr_i(wr_addr), .wr_data_i(wr_data), .out_valid_o(out_valid),
    .out_idx_o(out_idx), .out_val_o(out_val), .done_o(done), .overrun_o(overrun));

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int rnd12();
    return int'($signed(12'($urandom())));
  endfunction

  function automatic logic [15:0] lfsr_next(input logic [15:0] s);
    return {s[14:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
  endfunction

  // expected result for population p with noise state s (R3..R6)
  function automatic int model(input int p, input logic [15:0] s);
    longint acc, t;
    int e, nz;
    e = ((inp_m[p] & 12'hFFF) >> 4) ^ 128;
    acc = 0;
    for (int k = 0; k < NB; k++) acc += longint'(w_m[p][k]) * longint'(b_m[e][k]);
    nz = (int'($signed(s[15:4])) * a_m[p]) >>> 8;
    t = (acc >>> 11) + nz;
    if (t > 2047) t = 2047;
    if (t < -2048) t = -2048;
    return int'(t);
  endfunction

  task automatic wr(input int sel, input int addr, input int data);
    @(negedge clk);
    wr_en = 1; wr_sel = 2'(sel); wr_addr = AW'(addr); wr_data = 12'(data);
  endtask

  task automatic wr_end();
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic set_inp(input int p, input int v);  inp_m[p] = v; wr(0, p, v); endtask
  task automatic set_w(input int p, input int k, input int v); w_m[p][k] = v; wr(1, p*NB + k, v); endtask
  task automatic set_b(input int e, input int k, input int v); b_m[e][k] = v; wr(2, e*NB + k, v); endtask
  task automatic set_a(input int p, input int v); a_m[p] = v; wr(3, p, v); endtask

  task automatic load_random(input bit noise_on);
    for (int p = 0; p < NPOP; p++) begin
      set_inp(p, rnd12());
      set_a(p, noise_on ? int'($urandom_range(255)) : 0);
      for (int k = 0; k < NB; k++) set_w(p, k, rnd12());
    end
    wr_end();
  endtask

  // one sweep; optionally inject a strobe mid-sweep (R8)
  task automatic run_step(input string tag, input bit inject);
    int cnt;
    bit seen_done;
    cnt = 0; seen_done = 0;
    @(negedge clk); step = 1;
    @(negedge clk); step = 0;
    chk({tag, " R9 done cleared after strobe"}, int'(done), 0);
    for (int k = 1; k <= 3*NPOP + 12 && !seen_done; k++) begin
      @(negedge clk);
      if (inject && k == 4) step = 1;
      if (inject && k == 5) step = 0;
      if (out_valid) begin
        chk({tag, " R2 output order"}, int'(out_idx), cnt);
        chk({tag, " R3 output value"}, int'($signed(out_val)), model(cnt % NPOP, ns));
        ns = lfsr_next(ns);
        cnt++;
      end
      if (done) begin
        seen_done = 1;
        chk({tag, " R2 done cycle"}, k, 3*NPOP);
        chk({tag, " R2 output count"}, cnt, NPOP);
      end
    end
    if (!seen_done) chk({tag, " R2 done seen"}, 0, 1);
    if (inject) chk({tag, " R8 overrun set"}, int'(overrun), 1);
  endtask

  initial begin
    void'($urandom(32'd1234));
    ns = 16'hACE1;
    for (int p = 0; p < NPOP; p++) begin
      inp_m[p] = 0; a_m[p] = 0;
      for (int k = 0; k < NB; k++) w_m[p][k] = 0;
    end
    repeat (3) @(negedge clk);
    chk("R1 valid in reset", int'(out_valid), 0);
    chk("R1 done in reset", int'(done), 0);
    rst_n = 1;
    repeat (4) @(negedge clk);
    chk("R1 valid after reset", int'(out_valid), 0);
    chk("R1 done after reset", int'(done), 0);
    chk("R1 overrun after reset", int'(overrun), 0);

    // R10: full basis bank, random network
    for (int e = 0; e < NLUT; e++)
      for (int k = 0; k < NB; k++) set_b(e, k, rnd12());
    load_random(1);
    // R4 corners: most negative input and zero
    set_inp(0, -2048); set_inp(1, 0); set_inp(2, 2047); wr_end();
    run_step("s1", 0);
    repeat (5) @(negedge clk);
    chk("R9 done holds", int'(done), 1);
    chk("R8 no overrun yet", int'(overrun), 0);

    // R7: noise state carries into a second sweep with new inputs
    for (int p = 0; p < NPOP; p++) set_inp(p, rnd12());
    wr_end();
    run_step("s2", 0);

    // R6: zero amplitude removes noise
    load_random(0);
    run_step("s3 R6", 0);

    // R5: saturate high and low
    for (int p = 0; p < NPOP; p++) begin
      set_inp(p, 0);
      set_a(p, 255);
      for (int k = 0; k < NB; k++) set_w(p, k, 2047);
    end
    for (int k = 0; k < NB; k++) set_b(128, k, 2047);
    wr_end();
    run_step("s4 R5 high", 0);
    for (int k = 0; k < NB; k++) set_b(128, k, -2048);
    wr_end();
    run_step("s5 R5 low", 0);

    // R8: strobe during sweep is ignored but flagged
    load_random(1);
    run_step("s6", 1);
    run_step("s7", 0);
    chk("R8 overrun sticky", int'(overrun), 1);

    // R10: rewriting one weight changes only via model
    set_w(3, 5, 2047); set_w(3, 6, -2048); wr_end();
    for (int r = 0; r < 4; r++) begin
      load_random(1);
      run_step("rnd R10", 0);
    end

    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      total++; bad++;
      $display("FAIL watchdog R2 actual=hung expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule